// File: doc/BRIEF.md
# Windowed Four-State Viterbi Segment Decoder

This block decodes one fixed-length window of a rate-1/2, constraint-length-3 convolutional code with a four-state trellis. Several copies can run side by side, each on its own overlapping slice of the received stream. No copy needs anything from its neighbours. Each window starts cold: every path metric is zero because the encoder state at the window edge is unknown. The block accepts `WIN_LEN` steps of branch metrics, runs the add-compare-select recursion with maximum selection, and keeps one survivor decision bit per state per step.

When the window is full, the block traces back one step per clock from state 0. It starts at the end of the window and fills a bit array. The head of the window is not yet reliable, and in the tail the survivors have not merged, so `SURV_D` steps are dropped at each end. Only the `WIN_LEN - 2*SURV_D` middle bits are emitted, in time order, followed by a single completion pulse. A caller that needs a given block decoded feeds it padded with `SURV_D` extra steps on each side. Splitting the stream into windows and joining the outputs is left to the surrounding logic.

Top module: `vit_window_dec`

## Requirements
- R1: After reset, `out_valid`, `done` and `busy` are all low.
- R2: A `start` seen while idle opens a new window and clears all four path metrics to zero. `busy` is high in the cycle after that edge. A window decoded right after another one gives the same result as a first window.
- R3: Exactly `WIN_LEN` beats with `bm_valid` high are taken into a window, and cycles with `bm_valid` low inside the window are skipped. `bm_valid` has no effect while idle or after the window is full.
- R4: Step arithmetic works as follows. A state is {u(k-1), u(k-2)}, and input u moves state s to {u, s[1]}. The code symbol is {c0, c1}, with c0 = u^s[1]^s[0] and c1 = u^s[0]. `bm_vec[j*BM_W +: BM_W]` is the metric of symbol j. Each new metric is the larger of the two candidates. A tie keeps the predecessor whose low state bit is 0.
- R5: Traceback begins at state 0 after the last step. It recovers each step's input as the high bit of the state reached by that step.
- R6: The block emits exactly `WIN_LEN - 2*SURV_D` bits, for 0-based steps `SURV_D` to `WIN_LEN-SURV_D-1`. The bits come in increasing order on consecutive cycles with `out_valid` high. On a noise-free window they equal the encoded data.
- R7: The first `out_valid` comes exactly `WIN_LEN - SURV_D + 1` clock edges after the edge that takes the last beat.
- R8: `done` is a one-cycle pulse in the cycle right after the last `out_valid`. It is never high together with `out_valid`.
- R9: `busy` stays high from the edge that accepts `start` until `done` rises, and it is low while `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored. The running window completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Open a new window (taken only when idle) |
| bm_valid | input | 1 | Branch metric beat valid |
| bm_vec | input | 4*BM_W | Four branch metrics, indexed by code symbol |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded data bit |
| done | output | 1 | One-cycle pulse after the last decoded bit |
| busy | output | 1 | Window in progress |

## Verification
The hardest case to reach from the ports is an input arriving while the block is in a phase where it must have no effect. Examples are a `start` or extra metric beats during traceback, or a `start` in the middle of filling. Such inputs could silently corrupt stored decisions without changing any timing. The bench raises these inputs at fixed points inside specific windows. It then checks, cycle by cycle against a timing model, that the decoded middle segment still equals the encoded data bit for bit. A second delicate case is the tie rule. A window whose branch metrics are all zero forces a tie at every compare, and the rule fixes the emitted bits to all zeros.

// File: rtl/vit_win_pkg.sv
package vit_win_pkg;

    localparam int NUM_ST = 4;
    localparam int ST_W   = 2;
    localparam int SYM_W  = 2;

    typedef logic [ST_W-1:0]  st_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_TRACE,
        PH_EMIT,
        PH_FIN
    } phase_e;

    // predecessor of state ns whose older bit is d
    function automatic st_t pred_of(input st_t ns, input logic d);
        return {ns[0], d};
    endfunction

    // code symbol on the branch leaving state s on input u
    function automatic sym_t code_sym(input st_t s, input logic u);
        logic c0;
        logic c1;
        c0 = u ^ s[1] ^ s[0];
        c1 = u ^ s[0];
        return {c0, c1};
    endfunction

endpackage

// File: rtl/vit_acs_bank.sv
module vit_acs_bank
    import vit_win_pkg::*;
#(
    parameter int BM_W = 2,
    parameter int PM_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     en,
    input  logic [NUM_ST*BM_W-1:0]   bm_vec,
    output logic [NUM_ST-1:0]        dec_o
);

    logic [PM_W-1:0] pm_q  [NUM_ST];
    logic [PM_W-1:0] pm_nx [NUM_ST];

    for (genvar g = 0; g < NUM_ST; g++) begin : g_state
        localparam st_t  NS = st_t'(g);
        localparam st_t  P0 = pred_of(NS, 1'b0);
        localparam st_t  P1 = pred_of(NS, 1'b1);
        localparam sym_t S0 = code_sym(P0, NS[1]);
        localparam sym_t S1 = code_sym(P1, NS[1]);

        logic [PM_W-1:0] cand0;
        logic [PM_W-1:0] cand1;

        assign cand0    = pm_q[P0] + PM_W'(bm_vec[int'(S0)*BM_W +: BM_W]);
        assign cand1    = pm_q[P1] + PM_W'(bm_vec[int'(S1)*BM_W +: BM_W]);
        assign dec_o[g] = (cand1 > cand0);
        assign pm_nx[g] = dec_o[g] ? cand1 : cand0;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                pm_q[g] <= '0;
            end else if (en) begin
                pm_q[g] <= pm_nx[g];
            end
        end
    end

endmodule

// File: rtl/vit_surv_store.sv
module vit_surv_store
    import vit_win_pkg::*;
#(
    parameter int WIN_LEN = 40,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [NUM_ST-1:0]  dec_i,
    input  logic               tb_start,
    input  logic               tb_en,
    input  logic [IDX_W-1:0]   tb_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_bit
);

    logic [NUM_ST-1:0]  dec_mem [WIN_LEN];
    logic [WIN_LEN-1:0] bits_q;
    st_t                cur_q;
    logic               step_dec;

    assign step_dec = dec_mem[tb_idx][cur_q];
    assign rd_bit   = bits_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dec_mem[wr_idx] <= dec_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            bits_q <= '0;
        end else if (tb_start) begin
            cur_q <= '0;
        end else if (tb_en) begin
            bits_q[tb_idx] <= cur_q[1];
            cur_q          <= pred_of(cur_q, step_dec);
        end
    end

endmodule

// File: rtl/vit_window_dec.sv
module vit_window_dec
    import vit_win_pkg::*;
#(
    parameter int WIN_LEN = 40,
    parameter int SURV_D  = 12,
    parameter int BM_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    bm_valid,
    input  logic [4*BM_W-1:0]       bm_vec,
    output logic                    out_valid,
    output logic                    out_bit,
    output logic                    done,
    output logic                    busy
);

    localparam int IDX_W = $clog2(WIN_LEN);
    localparam int PM_W  = BM_W + $clog2(WIN_LEN + 1);
    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(WIN_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(SURV_D);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(WIN_LEN - SURV_D - 1);

    phase_e             phase_q;
    logic [IDX_W-1:0]   idx_q;
    logic               acs_clr;
    logic               acs_en;
    logic               tb_start;
    logic               tb_en;
    logic [NUM_ST-1:0]  dec_w;
    logic               rd_bit;

    assign acs_clr  = (phase_q == PH_IDLE) && start;
    assign acs_en   = (phase_q == PH_FILL) && bm_valid;
    assign tb_start = acs_en && (idx_q == IDX_END);
    assign tb_en    = (phase_q == PH_TRACE);
    assign busy     = (phase_q != PH_IDLE);

    vit_acs_bank #(
        .BM_W (BM_W),
        .PM_W (PM_W)
    ) acs_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (acs_clr),
        .en     (acs_en),
        .bm_vec (bm_vec),
        .dec_o  (dec_w)
    );

    vit_surv_store #(
        .WIN_LEN (WIN_LEN),
        .IDX_W   (IDX_W)
    ) surv_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acs_en),
        .wr_idx   (idx_q),
        .dec_i    (dec_w),
        .tb_start (tb_start),
        .tb_en    (tb_en),
        .tb_idx   (idx_q),
        .rd_idx   (idx_q),
        .rd_bit   (rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            idx_q     <= '0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_FILL;
                        idx_q   <= '0;
                    end
                end
                PH_FILL: begin
                    if (bm_valid) begin
                        if (idx_q == IDX_END) begin
                            phase_q <= PH_TRACE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_TRACE: begin
                    if (idx_q == IDX_FIRST) begin
                        phase_q <= PH_EMIT;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                PH_EMIT: begin
                    out_valid <= 1'b1;
                    out_bit   <= rd_bit;
                    if (idx_q == IDX_LAST) begin
                        phase_q <= PH_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_FIN: begin
                    done    <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vit_window_dec_chk.sv
module vit_window_dec_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic out_valid,
    input logic done,
    input logic busy
);

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);                                   // R6

    AST_VALID_RUN_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> done);                            // R6

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid) && !out_valid));            // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                       // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                       // R9

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                            // R2

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                 // R9

endmodule

bind vit_window_dec vit_window_dec_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy)
);

// File: tb/vit_window_dec_tb_top.sv
module vit_window_dec_tb_top;

    localparam int E   = 40;
    localparam int D   = 12;
    localparam int BMW = 2;
    localparam int FIRST_N = E - D + 1;
    localparam int LAST_N  = 2*E - 3*D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bm_valid = 1'b0;
    logic [4*BMW-1:0] bm_vec = '0;
    logic out_valid;
    logic out_bit;
    logic done;
    logic busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit data [E];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vit_window_dec #(.WIN_LEN(E), .SURV_D(D), .BM_W(BMW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .bm_valid(bm_valid),
        .bm_vec(bm_vec), .out_valid(out_valid), .out_bit(out_bit),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [4*BMW-1:0] metrics_for(input int rx);
        logic [4*BMW-1:0] v;
        v = '0;
        for (int j = 0; j < 4; j++) begin
            v[j*BMW +: BMW] = BMW'(2 - $countones(2'(j) ^ 2'(rx)));
        end
        return v;
    endfunction

    // kind: 0 random, 1 all ones, 2 alternating, 3 all-zero metrics
    task automatic run_window(input int kind, input bit gaps, input bit inject,
                              input string tag);
        bit s1;
        bit s0;
        int rx;
        s1 = 0;
        s0 = 0;
        for (int k = 0; k < E; k++) begin
            case (kind)
                0: data[k] = 1'($urandom_range(0, 1));
                1: data[k] = 1'b1;
                2: data[k] = 1'(k % 2);
                default: data[k] = 1'b0;
            endcase
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int k = 0; k < E; k++) begin
            if (gaps && (k % 7 == 3)) begin
                bm_valid = 1'b0;
                bm_vec   = 8'hFF;
                @(negedge clk);
            end
            rx = {int'(data[k] ^ s1 ^ s0), int'(data[k] ^ s0)} ;
            rx = ((data[k] ^ s1 ^ s0) << 1) | (data[k] ^ s0);
            s0 = s1;
            s1 = data[k];
            bm_valid = 1'b1;
            bm_vec   = (kind == 3) ? '0 : metrics_for(rx);
            start    = inject && (k == 20);
            @(negedge clk);
        end
        start = 1'b0;
        for (int n = 0; n <= LAST_N + 2; n++) begin
            bit ev;
            bit eb;
            ev = (n >= FIRST_N) && (n <= LAST_N);
            chk(out_valid == ev, "R7 out_valid timing", int'(out_valid), int'(ev));
            chk(done == (n == LAST_N + 1), "R8 done pulse", int'(done), int'(n == LAST_N + 1));
            chk(busy == (n <= LAST_N), "R9 busy span", int'(busy), int'(n <= LAST_N));
            if (ev && out_valid) begin
                eb = (kind == 3) ? 1'b0 : data[D + n - FIRST_N];
                chk(out_bit == eb, tag, int'(out_bit), int'(eb));
            end
            bm_valid = inject && (n < 4);
            bm_vec   = 8'h5A;
            start    = inject && (n == 5);
            @(negedge clk);
        end
        bm_valid = 1'b0;
        start    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1 out_valid reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);

        // R3: metric beats while idle do nothing
        for (int i = 0; i < 3; i++) begin
            bm_valid = 1'b1;
            bm_vec   = 8'(i * 37 + 11);
            @(negedge clk);
            chk(busy == 1'b0 && out_valid == 1'b0, "R3 idle beat ignored",
                int'(busy), 0);
        end
        bm_valid = 1'b0;

        run_window(0, 1'b0, 1'b0, "R5 R6 random bit");
        run_window(0, 1'b0, 1'b0, "R2 cold restart bit");
        run_window(1, 1'b0, 1'b0, "R4 ones bit");
        run_window(2, 1'b0, 1'b0, "R4 alternating bit");
        run_window(0, 1'b1, 1'b1, "R3 R10 gaps and stray inputs bit");
        run_window(3, 1'b0, 1'b0, "R4 tie rule bit");
        run_window(0, 1'b1, 1'b0, "R6 random gapped bit");

        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 idle after stray start", int'(busy), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule